// File: doc/BRIEF.md
# Serial Systematic (7,4) Cyclic Encoder

This block turns a stream of 4-bit messages into 7-bit codewords of a binary cyclic code. Message bits enter one per accepted cycle, highest-degree coefficient first, and are forwarded unchanged to the serial output one cycle later. While they pass through, a division-feedback shift register builds the remainder of p^3·M(p) modulo the generator polynomial G(p). After the fourth message bit the output multiplexer switches to the register, and the three check bits leave top stage first.

While the check bits are leaving, the input is held off with a ready signal. The register is empty when the next message starts, so consecutive codewords do not affect each other. The generator is a parameter: a coefficient vector whose bit i holds the coefficient of p^i. Its default is 1+p+p^3 (`4'b1011`). Any degree-3 factor of p^7+1 with both end coefficients set to 1 is a legal generator. The output has no stall input, so the consumer must take a bit on every cycle that `code_valid` is high.

Top module: `syscyc_enc`

## Requirements
- R1: After reset `code_valid` and `code_last` are 0 and `msg_ready` is 1, and a message sent after a reset part-way through a word encodes as if no earlier bits had been sent.
- R2: A message bit accepted on a clock edge (`msg_valid` and `msg_ready` both 1) appears on `code_bit` with `code_valid` high after that same edge.
- R3: The fifth, sixth and seventh output bits are check bits c2, c1, c0 of C(p) = p^3·M(p) mod G(p), in that order. For the default generator, message 1101 (m3..m0) gives check bits 001.
- R4: Every emitted 7-bit codeword, read first bit as the p^6 coefficient, is an exact multiple of G(p).
- R5: With G(p) = 1+p^2+p^3 (parameter `4'b1101`), check bits again equal p^3·M(p) mod G(p).
- R6: `msg_ready` is low for exactly the three check-bit cycles of each word, and `code_valid` is high on each of them. Values on `msg_valid` and `msg_bit` during those cycles do not change the codeword.
- R7: `code_last` is high on the seventh bit of each codeword and on no other cycle.
- R8: A cycle in the message phase with `msg_valid` low produces no output bit on the following cycle and does not advance the word.
- R9: Back-to-back messages encode independently: message 0000 right after message 1111 gives the all-zero codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_bit | input | 1 | Serial message bit, highest degree first |
| msg_valid | input | 1 | `msg_bit` holds a message bit |
| msg_ready | output | 1 | Encoder accepts a message bit this cycle |
| code_bit | output | 1 | Serial codeword bit |
| code_valid | output | 1 | `code_bit` holds a codeword bit |
| code_last | output | 1 | Marks the final bit of a codeword |

## Verification
The assertions assume the consumer takes every output bit as it comes, since there is no stall input on the output side. They also assume the generator parameter has its constant and degree-3 coefficients set. The bench never holds back an output. It uses only the two legal generators, 1+p+p^3 and 1+p^2+p^3. While `msg_ready` is low it may drive `msg_valid` high with junk bits, but the encoder should ignore them. Message-phase stimulus includes both dense runs and runs with idle gaps, which exercises the hold-off and idle paths that the assertions watch.

// File: rtl/syscyc_enc.sv
module syscyc_enc #(
  parameter int N = 7,
  parameter int K = 4,
  parameter logic [N-K:0] GEN = 4'b1011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_bit,
  input  logic msg_valid,
  output logic msg_ready,
  output logic code_bit,
  output logic code_valid,
  output logic code_last
);
  localparam int Q  = N - K;
  localparam int CW = $clog2(N);

  logic [CW-1:0] cnt;
  logic [Q-1:0]  rem;

  wire          in_msg  = cnt < CW'(K);
  wire          take    = msg_valid & in_msg;
  wire          fb      = msg_bit ^ rem[Q-1];
  wire [Q-1:0]  shifted = {rem[Q-2:0], 1'b0};
  wire          at_end  = cnt == CW'(N - 1);

  assign msg_ready = in_msg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rem        <= '0;
      code_bit   <= 1'b0;
      code_valid <= 1'b0;
      code_last  <= 1'b0;
    end else begin
      code_valid <= 1'b0;
      code_last  <= 1'b0;
      if (take) begin
        code_bit   <= msg_bit;
        code_valid <= 1'b1;
        rem        <= shifted ^ ({Q{fb}} & GEN[Q-1:0]);
        cnt        <= cnt + 1'b1;
      end else if (!in_msg) begin
        code_bit   <= rem[Q-1];
        code_valid <= 1'b1;
        code_last  <= at_end;
        rem        <= at_end ? '0 : shifted;
        cnt        <= at_end ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syscyc_enc_chk.sv
module syscyc_enc_chk #(
  parameter int N = 7,
  parameter int K = 4
) (
  input logic clk,
  input logic rst_n,
  input logic msg_bit,
  input logic msg_valid,
  input logic msg_ready,
  input logic code_bit,
  input logic code_valid,
  input logic code_last
);
  localparam int Q = N - K;

  logic [7:0] busy;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= '0;
    else if (msg_ready)  busy <= '0;
    else                 busy <= busy + 8'd1;
  end

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (code_valid && code_bit == $past(msg_bit)));

  // R6
  check_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |=> code_valid);

  // R6
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |-> busy < 8'(Q));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_last |-> (code_valid && msg_ready));

  // R8
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && !msg_valid) |=> !code_valid);
endmodule

bind syscyc_enc syscyc_enc_chk #(.N(N), .K(K)) u_chk (.*);

// File: tb/syscyc_enc_test.sv
`timescale 1ns/1ps
module syscyc_enc_test;
  localparam logic [3:0] GEN_A = 4'b1011;
  localparam logic [3:0] GEN_B = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_bit = 1'b0;
  logic msg_valid = 1'b0;
  logic msg_ready, code_bit, code_valid, code_last;
  logic msg_ready_b, code_bit_b, code_valid_b, code_last_b;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  syscyc_enc #(.N(7), .K(4), .GEN(GEN_A)) uut (
    .clk(clk), .rst_n(rst_n), .msg_bit(msg_bit), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .code_bit(code_bit), .code_valid(code_valid),
    .code_last(code_last));

  syscyc_enc #(.N(7), .K(4), .GEN(GEN_B)) uut_b (
    .clk(clk), .rst_n(rst_n), .msg_bit(msg_bit), .msg_valid(msg_valid),
    .msg_ready(msg_ready_b), .code_bit(code_bit_b), .code_valid(code_valid_b),
    .code_last(code_last_b));

  function automatic logic [2:0] rem7(input logic [6:0] w, input logic [3:0] g);
    for (int i = 6; i >= 3; i--)
      if (w[i]) w = w ^ (7'(g) << (i - 3));
    return w[2:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(code_valid == 1'b0, "R1 code_valid", code_valid, 0);
    chk(code_last == 1'b0, "R1 code_last", code_last, 0);
    chk(msg_ready == 1'b1, "R1 msg_ready", msg_ready, 1);
  endtask

  task automatic run_word(input logic [3:0] m, input bit gaps, input bit junk, input string tag);
    logic [6:0] got_a = '0;
    logic [6:0] got_b = '0;
    logic [6:0] exp_a, exp_b;
    int nout = 0, sent = 0, cyc = 0, last_at = -1, lasts = 0, low = 0;
    exp_a = {m, rem7({m, 3'b000}, GEN_A)};
    exp_b = {m, rem7({m, 3'b000}, GEN_B)};
    while (nout < 7 && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (code_valid) begin
        got_a[6 - nout] = code_bit;
        got_b[6 - nout] = code_bit_b;
        if (code_last) begin last_at = nout; lasts++; end
        nout++;
      end
      if (!msg_ready) low++;
      if (msg_ready && sent < 4 && !(gaps && cyc % 2 == 0)) begin
        msg_valid = 1'b1; msg_bit = m[3 - sent]; sent++;
      end else if (!msg_ready && junk) begin
        msg_valid = 1'b1; msg_bit = cyc[0];
      end else begin
        msg_valid = 1'b0; msg_bit = cyc[0];
      end
    end
    msg_valid = 1'b0;
    chk(nout == 7, {"R8 bit count ", tag}, nout, 7);
    chk(got_a[6:3] == m, {"R2 message bits ", tag}, got_a[6:3], m);
    chk(got_a[2:0] == exp_a[2:0], {"R3 check bits ", tag}, got_a[2:0], exp_a[2:0]);
    chk(rem7(got_a, GEN_A) == 3'b000, {"R4 multiple of G ", tag}, rem7(got_a, GEN_A), 0);
    chk(got_b == exp_b, {"R5 alt generator ", tag}, got_b, exp_b);
    chk(last_at == 6 && lasts == 1, {"R7 last flag ", tag}, last_at, 6);
    chk(low == 3, {"R6 ready low cycles ", tag}, low, 3);
  endtask

  task automatic test_idle(input int n);
    msg_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(code_valid == 1'b0 && code_last == 1'b0, "R8 idle output", code_valid, 0);
      chk(msg_ready == 1'b1, "R8 idle ready", msg_ready, 1);
    end
  endtask

  task automatic test_all_messages();
    for (int v = 0; v < 16; v++) run_word(4'(v), 1'b0, 1'b0, "dense");
  endtask

  task automatic test_known_value();
    run_word(4'b1101, 1'b0, 1'b0, "known");
    chk(rem7(7'b1101000, GEN_A) == 3'b001, "R3 known remainder", rem7(7'b1101000, GEN_A), 1);
  endtask

  task automatic test_gaps();
    run_word(4'b1011, 1'b1, 1'b0, "gaps");
    run_word(4'b0110, 1'b1, 1'b0, "gaps");
    test_idle(3);
  endtask

  task automatic test_junk();
    run_word(4'b1001, 1'b0, 1'b1, "junk");
    run_word(4'b0111, 1'b1, 1'b1, "junk");
  endtask

  task automatic test_back_to_back();
    run_word(4'b1111, 1'b0, 1'b0, "R9 first");
    run_word(4'b0000, 1'b0, 1'b0, "R9 zero");
  endtask

  task automatic test_mid_reset();
    @(negedge clk);
    msg_valid = 1'b1; msg_bit = 1'b1;
    @(negedge clk);
    msg_bit = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_word(4'b0010, 1'b0, 1'b0, "R1 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_known_value();
    test_all_messages();
    test_gaps();
    test_junk();
    test_back_to_back();
    test_mid_reset();
    test_idle(2);
    done = 1;
    summary();
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule